// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block joins two 18-bit ports, an A side and a B side, with one storage path for each direction. Each path is steered by three controls of its own: a drive enable, a pass enable and a strobe. With the pass enable high the path is transparent and its output follows its input. With the pass enable low the path holds its stored word, and takes in a new word only on a high-to-low transition of its strobe. So one storage element serves as a level-sensitive latch or as a falling-edge register, and the pass enable picks which.

The whole block runs on one free-running system clock. The pass enables and strobes are asynchronous to it, so each goes through a two-stage synchronizer. A strobe fall is found by comparing the newest synchronized sample with the one before it. The pins are not bidirectional. Each side has a separate input bus, output bus and drive flag, and a drive flag low stands for a high-impedance pin. The A-to-B drive enable is active high and the B-to-A one is active low. A flag is raised whenever both sides would drive at the same time. The data interfaces are level buses with no handshake, because the block has no flow control to offer.

Top module: `dual_latch_xcvr`

## Requirements
- R1: With a path's pass enable high, its output word equals its current input word, once the pass enable has been high for three system clock edges.
- R2: With the pass enable low and the strobe held at a steady level, either 0 or 1, the output keeps the stored word while the input word changes.
- R3: With the pass enable low, a 1-to-0 strobe transition stores the input word present at that time. A 0-to-1 transition stores nothing.
- R4: The A-to-B drive enable `ab_en` is active high. When it is 1, `b_drive` is 1 and `b_out` carries the A-to-B word. When it is 0, `b_drive` is 0 and `b_out` is all zeros.
- R5: The B-to-A drive enable `ba_en_n` is active low. When it is 0, `a_drive` is 1 and `a_out` carries the B-to-A word. When it is 1, `a_drive` is 0 and `a_out` is all zeros.
- R6: The two paths are independent. Activity on one path's data, pass enable or strobe leaves the other path's output unchanged.
- R7: If the strobe is low when the pass enable falls, the word held afterwards is the input word from just before the fall.
- R8: A change on a pass enable or strobe takes effect no later than the third rising system clock edge after it.
- R9: An active-low `rst_n` clears both stored words to zero. The drive flags still follow the drive enables, even while the block is in reset.
- R10: `contention` is 1 exactly when `a_drive` and `b_drive` are both 1.
- R11: While the pass enable is high, a strobe fall has no further effect. The word held after the pass enable drops is the last input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 18 | Word received from the A side |
| a_out | output | 18 | Word driven onto the A side (zero when not driving) |
| a_drive | output | 1 | A side drive flag; 0 means high impedance |
| b_in | input | 18 | Word received from the B side |
| b_out | output | 18 | Word driven onto the B side (zero when not driving) |
| b_drive | output | 1 | B side drive flag; 0 means high impedance |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ba_en_n | input | 1 | B-to-A drive enable, active low |
| ab_pass | input | 1 | A-to-B pass enable (transparent when 1) |
| ba_pass | input | 1 | B-to-A pass enable (transparent when 1) |
| ab_strobe | input | 1 | A-to-B capture strobe, falling edge active |
| ba_strobe | input | 1 | B-to-A capture strobe, falling edge active |
| contention | output | 1 | Both sides driving at once |

## Verification
The storage function is driven with transparent input changes, a held word under a steady-high and a steady-low strobe, a strobe fall against a strobe rise, a pass-enable fall with the strobe low, and a strobe fall while transparent. Each of these patterns separates latch behaviour from register behaviour, or a falling-edge capture from a rising-edge one. The two paths are run against each other, one holding and one transparent, to show that they share no state. All four drive enable combinations are applied to check each enable's polarity and the contention flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_WIDTH = 18;
  localparam int unsigned XCVR_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= 1'b0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W             = XCVR_WIDTH,
  parameter int unsigned SYNC_STAGES   = XCVR_SYNC_STAGES,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         pass_async,
  input  logic         strobe_async,
  input  logic         oe_raw,
  output logic [W-1:0] dout,
  output logic         drive,
  output logic         pass_q,
  output logic         strobe_fall,
  output logic [W-1:0] held
);
  logic        strobe_q;
  logic        strobe_prev;
  store_mode_e mode;
  logic [W-1:0] view;

  xcvr_sync #(.STAGES(SYNC_STAGES)) u_sync_pass (
    .clk(clk), .rst_n(rst_n), .d(pass_async), .q(pass_q)
  );

  xcvr_sync #(.STAGES(SYNC_STAGES)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d(strobe_async), .q(strobe_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_prev <= 1'b0;
    else        strobe_prev <= strobe_q;
  end

  assign strobe_fall = strobe_prev & ~strobe_q;

  always_comb begin
    if (pass_q)           mode = MODE_PASS;
    else if (strobe_fall) mode = MODE_CAPTURE;
    else                  mode = MODE_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 held <= '0;
    else if (mode != MODE_HOLD) held <= din;
  end

  assign view = (mode == MODE_PASS) ? din : held;

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign drive = ~oe_raw;
  end else begin : g_oe_high
    assign drive = oe_raw;
  end

  assign dout = drive ? view : '0;
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W           = XCVR_WIDTH,
  parameter int unsigned SYNC_STAGES = XCVR_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_en,
  input  logic         ba_en_n,
  input  logic         ab_pass,
  input  logic         ba_pass,
  input  logic         ab_strobe,
  input  logic         ba_strobe,
  output logic         contention
);
  logic         ab_pass_q, ab_fall;
  logic         ba_pass_q, ba_fall;
  logic [W-1:0] ab_held, ba_held;

  xcvr_path #(.W(W), .SYNC_STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk(clk), .rst_n(rst_n), .din(a_in), .pass_async(ab_pass),
    .strobe_async(ab_strobe), .oe_raw(ab_en), .dout(b_out), .drive(b_drive),
    .pass_q(ab_pass_q), .strobe_fall(ab_fall), .held(ab_held)
  );

  xcvr_path #(.W(W), .SYNC_STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk(clk), .rst_n(rst_n), .din(b_in), .pass_async(ba_pass),
    .strobe_async(ba_strobe), .oe_raw(ba_en_n), .dout(a_out), .drive(a_drive),
    .pass_q(ba_pass_q), .strobe_fall(ba_fall), .held(ba_held)
  );

  assign contention = a_drive & b_drive;
endmodule

// File: rtl/dual_latch_xcvr_chk.sv
module dual_latch_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_drive,
  input logic         b_drive,
  input logic         ab_en,
  input logic         ba_en_n,
  input logic         contention,
  input logic         ab_pass_q,
  input logic         ba_pass_q,
  input logic         ab_fall,
  input logic         ba_fall,
  input logic [W-1:0] ab_held,
  input logic [W-1:0] ba_held
);
  a_r1_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_pass_q && b_drive) |-> (b_out == a_in));

  a_r2_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass_q && !ab_fall) |=> $stable(ab_held));

  a_r2_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass_q && !ba_fall) |=> $stable(ba_held));

  a_r3_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass_q && ab_fall) |=> (ab_held == $past(a_in)));

  a_r3_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass_q && ba_fall) |=> (ba_held == $past(b_in)));

  a_r4_ab_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |-> (!b_drive && b_out == '0));

  a_r5_ba_off: assert property (@(posedge clk) disable iff (!rst_n)
    ba_en_n |-> (!a_drive && a_out == '0));

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ab_held == '0 && ba_held == '0));

  a_r10_contention: assert property (@(posedge clk) disable iff (!rst_n)
    contention == (a_drive && b_drive));
endmodule

bind dual_latch_xcvr dual_latch_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .a_out(a_out),
  .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive), .ab_en(ab_en),
  .ba_en_n(ba_en_n), .contention(contention), .ab_pass_q(ab_pass_q),
  .ba_pass_q(ba_pass_q), .ab_fall(ab_fall), .ba_fall(ba_fall),
  .ab_held(ab_held), .ba_held(ba_held)
);

// File: tb/tb_dual_latch_xcvr.sv
`timescale 1ns/1ps
module tb_dual_latch_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive, contention;
  logic         ab_en = 1'b1, ba_en_n = 1'b0;
  logic         ab_pass = 1'b0, ba_pass = 1'b0;
  logic         ab_strobe = 1'b0, ba_strobe = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_latch_xcvr dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive), .ab_en(ab_en),
    .ba_en_n(ba_en_n), .ab_pass(ab_pass), .ba_pass(ba_pass),
    .ab_strobe(ab_strobe), .ba_strobe(ba_strobe), .contention(contention)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    wait_cyc(2);
    chk("R9 reset drive b", {17'd0, b_drive}, 18'd1);
    chk("R9 reset drive a", {17'd0, a_drive}, 18'd1);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R9 cleared b_out", b_out, '0);
    chk("R9 cleared a_out", a_out, '0);
  endtask

  task automatic t_transparent;
    ab_pass = 1'b1;
    a_in = 18'h15A5A;
    wait_cyc(4);
    chk("R1 pass first", b_out, 18'h15A5A);
    a_in = 18'h2C3C3;
    wait_cyc(1);
    chk("R1 pass follows", b_out, 18'h2C3C3);
  endtask

  task automatic t_pass_fall_hold;
    ab_strobe = 1'b0;
    a_in = 18'h0BEEF;
    wait_cyc(4);
    ab_pass = 1'b0;
    wait_cyc(4);
    a_in = 18'h31111;
    wait_cyc(4);
    chk("R7 held after pass fall", b_out, 18'h0BEEF);
  endtask

  task automatic t_hold_and_capture;
    a_in = 18'h22222;
    ab_strobe = 1'b1;
    wait_cyc(4);
    chk("R3 rise stores nothing", b_out, 18'h0BEEF);
    a_in = 18'h12345;
    wait_cyc(3);
    chk("R2 hold strobe high", b_out, 18'h0BEEF);
    ab_strobe = 1'b0;
    wait_cyc(4);
    chk("R3 fall captures", b_out, 18'h12345);
    a_in = 18'h3FFFF;
    wait_cyc(5);
    chk("R2 hold strobe low", b_out, 18'h12345);
  endtask

  task automatic t_latency;
    a_in = 18'h00777;
    ab_strobe = 1'b1;
    wait_cyc(4);
    ab_strobe = 1'b0;
    wait_cyc(3);
    chk("R8 capture within three edges", b_out, 18'h00777);
  endtask

  task automatic t_ba_capture;
    ba_pass = 1'b0;
    b_in = 18'h2AAAA;
    ba_strobe = 1'b1;
    wait_cyc(4);
    ba_strobe = 1'b0;
    wait_cyc(4);
    b_in = 18'h05555;
    wait_cyc(4);
    chk("R3 ba fall captures", a_out, 18'h2AAAA);
  endtask

  task automatic t_independent;
    ba_pass = 1'b1;
    b_in = 18'h01010;
    wait_cyc(4);
    chk("R6 ba transparent", a_out, 18'h01010);
    b_in = 18'h36363;
    ba_strobe = 1'b1;
    wait_cyc(4);
    ba_strobe = 1'b0;
    wait_cyc(4);
    chk("R6 ab unaffected", b_out, 18'h00777);
    ba_pass = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_strobe_while_pass;
    ab_pass = 1'b1;
    ab_strobe = 1'b1;
    a_in = 18'h11111;
    wait_cyc(4);
    ab_strobe = 1'b0;
    wait_cyc(2);
    a_in = 18'h24680;
    wait_cyc(4);
    chk("R11 still follows", b_out, 18'h24680);
    ab_pass = 1'b0;
    wait_cyc(4);
    a_in = 18'h13579;
    wait_cyc(4);
    chk("R11 holds last input", b_out, 18'h24680);
  endtask

  task automatic t_enables;
    ab_en = 1'b0;
    ba_en_n = 1'b0;
    wait_cyc(1);
    chk("R4 b off drive", {17'd0, b_drive}, 18'd0);
    chk("R4 b off data", b_out, '0);
    chk("R10 no contention", {17'd0, contention}, 18'd0);
    chk("R5 a on drive", {17'd0, a_drive}, 18'd1);
    ba_en_n = 1'b1;
    wait_cyc(1);
    chk("R5 a off drive", {17'd0, a_drive}, 18'd0);
    chk("R5 a off data", a_out, '0);
    ab_en = 1'b1;
    wait_cyc(1);
    chk("R4 b on data", b_out, 18'h24680);
    chk("R10 one side", {17'd0, contention}, 18'd0);
    ba_en_n = 1'b0;
    wait_cyc(1);
    chk("R10 contention", {17'd0, contention}, 18'd1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_transparent();
        t_pass_fall_hold();
        t_hold_and_capture();
        t_latency();
        t_ba_capture();
        t_independent();
        t_strobe_while_pass();
        t_enables();
      end
      begin
        wait_cyc(20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule